// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block turns reads on a memory-mapped window into serial flash read transactions. A one-bit routing control decides who owns the flash pins. When the bit is set, the block owns them. When it is clear, a separate command engine owns them and this block leaves the pins undriven.

Each chip select has its own setup word. The setup word holds the read opcode, the number of address bytes, the number of dummy bytes and the width of the data phase. A read on the window proceeds as follows:
- The block asserts the selected chip select.
- It shifts out the opcode, the address and the dummy bytes, all on a single output line. The address is the low bytes of the window offset.
- It clocks in 32 data bits on one, two or four lines.
- It returns the assembled word on a request/ready read port.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset every chip select output is high, the serial clock is low, the output enable is low, the ready output is low, and the routing bit (`pinOwn`) is 0.
- R2: A read requested while the routing bit is clear completes with `rdReady` high and `rdErr` high. No chip select falls and no serial clock edge occurs during that read.
- R3: A configuration write to offset 0x40 loads the routing bit from data bit 0, and `pinOwn` follows it. Writing 1 hands the pins to this block and writing 0 releases them.
- R4: The setup word for chip select n is written at offset 0x54 + 4n. Its bits 7:0 are the opcode. The opcode is sent first, most significant bit first, on `flashMosi`.
- R5: Setup bits 9:8 hold the address byte count minus one. After the opcode, that many low bytes of the window offset are sent most significant bit first.
- R6: Setup bits 11:10 hold the dummy byte count (0 to 3). `flashMosi` is held low for 8 clocks per dummy byte.
- R7: Setup bits 13:12 select the data phase width:
  - 0: single line, 32 clocks, input line 1.
  - 1: dual, 16 clocks, lines 1:0 with line 1 first.
  - 3: quad, 8 clocks, lines 3:0 with line 3 as the most significant.
- R8: The first data bit received becomes bit 31 of `rdData`. The returned word is therefore assembled most significant byte first.
- R9: Only the chip select named by `rdCs` falls during a read. All chip selects are high while `rdReady` is high, and each access gives exactly one falling edge.
- R10: A successful read raises `rdReady` for exactly one cycle with `rdErr` low.
- R11: The serial clock idles low and is high only while a chip select is asserted. `flashMosi` never changes while the serial clock is high. The flash samples on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWdata | input | 32 | Configuration write data |
| rdReq | input | 1 | Window read request, held until ready |
| rdCs | input | CS_W | Chip select index of the read |
| rdAddr | input | ADDR_W | Window offset used as flash address |
| rdReady | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Assembled read word |
| rdErr | output | 1 | Read refused because pins are not owned |
| pinOwn | output | 1 | Routing bit: pins belong to this block |
| flashCsN | output | NUM_CS | Active-low chip selects |
| flashSclk | output | 1 | Serial clock |
| flashMosi | output | 1 | Serial command/address line |
| flashOe | output | 1 | Output enable for the command line |
| flashDin | input | 4 | Flash data input lines |

## Verification
Wrong internal state shows at the ports within the same access. Some faults affect the length of the command phase:
- A bad bit counter or a bad count decode shifts the opcode/address boundary seen by the flash model.
- The flash then mis-decodes the opcode or the address, and the returned word is wrong by the time `rdReady` rises.

Other faults show up as follows:
- A wrong data-width latch changes the number of data clocks and the bit order of `rdData`.
- A stale chip select index, or a state stuck outside idle, shows as the wrong line falling or as chip select held across the response cycle.
- Mishandling of the routing bit shows as pin activity on a refused read.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_RESP} seqState_t;

  typedef struct packed {
    logic load;
    logic txShift;
    logic rxSample;
  } seqStrobes_t;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_DUAL   = 2'd1;
  localparam logic [1:0] MODE_QUAD   = 2'd3;
  localparam int         SETUP_W     = 14;
  localparam int         CNT_W       = 7;
endpackage

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int ADDR_W     = 24,
  parameter int CS_W       = 2,
  parameter logic [7:0] SETUP_BASE = 8'h54,
  parameter logic [7:0] SWITCH_OFS = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic [CS_W-1:0]   rdCs,
  input  logic [ADDR_W-1:0] rdAddr,
  input  seqStrobes_t       strb,
  input  logic [3:0]        flashDin,
  output logic              switchOn,
  output logic [CNT_W-1:0]  cmdBits,
  output logic [1:0]        curMode,
  output logic              txBit,
  output logic [31:0]       rdWord
);
  localparam int TX_W = 40;

  logic [SETUP_W-1:0] setupQ [NUM_CS];
  logic [SETUP_W-1:0] selSetup;
  logic [TX_W-1:0]    txQ;
  logic [31:0]        rxQ;
  logic [31:0]        addrJust;
  logic [31:0]        unusedCfgBits;

  assign unusedCfgBits = cfgWdata;

  // One setup word per chip select, each at its own offset
  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_setup
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) setupQ[gi] <= '0;
      else if (cfgWe && cfgAddr == SETUP_BASE + 8'(4 * gi))
        setupQ[gi] <= cfgWdata[SETUP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) switchOn <= 1'b0;
    else if (cfgWe && cfgAddr == SWITCH_OFS) switchOn <= cfgWdata[0];
  end

  assign selSetup = setupQ[rdCs];

  // Serial command length: opcode + address bytes + dummy bytes
  assign cmdBits = CNT_W'(8) + (CNT_W'(selSetup[9:8]) + CNT_W'(1)) * CNT_W'(8)
                 + CNT_W'(selSetup[11:10]) * CNT_W'(8);

  // Address left-justified so its first byte leaves right after the opcode
  assign addrJust = 32'(rdAddr) << (5'd8 * (5'd3 - 5'(selSetup[9:8])));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ     <= '0;
      curMode <= MODE_SINGLE;
    end else if (strb.load) begin
      txQ     <= {selSetup[7:0], addrJust};
      curMode <= selSetup[13:12];
    end else if (strb.txShift) begin
      txQ     <= txQ << 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxQ <= '0;
    else if (strb.rxSample) begin
      case (curMode)
        MODE_QUAD: rxQ <= {rxQ[27:0], flashDin};
        MODE_DUAL: rxQ <= {rxQ[29:0], flashDin[1:0]};
        default:   rxQ <= {rxQ[30:0], flashDin[1]};
      endcase
    end
  end

  assign txBit  = txQ[TX_W-1];
  assign rdWord = rxQ;
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic [CS_W-1:0]  rdCs,
  input  logic             switchOn,
  input  logic [CNT_W-1:0] cmdBits,
  input  logic [1:0]       curMode,
  output seqStrobes_t      strb,
  output logic             sclk,
  output logic             csActive,
  output logic             cmdPhase,
  output logic [CS_W-1:0]  csIdx,
  output logic             respValid,
  output logic             respErr
);
  seqState_t        state;
  logic             half;
  logic [CNT_W-1:0] cnt;
  logic             errQ;
  logic [CNT_W-1:0] dataCycles;

  always_comb begin
    case (curMode)
      MODE_QUAD: dataCycles = CNT_W'(8);
      MODE_DUAL: dataCycles = CNT_W'(16);
      default:   dataCycles = CNT_W'(32);
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && rdReq && switchOn;
    strb.txShift  = (state == ST_CMD) && half;
    strb.rxSample = (state == ST_DATA) && !half;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      half  <= 1'b0;
      cnt   <= '0;
      errQ  <= 1'b0;
      csIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rdReq) begin
          half <= 1'b0;
          if (switchOn) begin
            state <= ST_CMD;
            cnt   <= cmdBits - CNT_W'(1);
            csIdx <= rdCs;
            errQ  <= 1'b0;
          end else begin
            state <= ST_RESP;
            errQ  <= 1'b1;
          end
        end
        ST_CMD: begin
          half <= !half;
          if (half) begin
            if (cnt == '0) begin
              state <= ST_DATA;
              cnt   <= dataCycles - CNT_W'(1);
            end else cnt <= cnt - CNT_W'(1);
          end
        end
        ST_DATA: begin
          half <= !half;
          if (half) begin
            if (cnt == '0) state <= ST_RESP;
            else cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk      = half;
  assign csActive  = (state == ST_CMD) || (state == ST_DATA);
  assign cmdPhase  = (state == ST_CMD);
  assign respValid = (state == ST_RESP);
  assign respErr   = (state == ST_RESP) && errQ;
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import flash_rd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              rdReq,
  input  logic [CS_W-1:0]   rdCs,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdReady,
  output logic [31:0]       rdData,
  output logic              rdErr,
  output logic              pinOwn,
  output logic [NUM_CS-1:0] flashCsN,
  output logic              flashSclk,
  output logic              flashMosi,
  output logic              flashOe,
  input  logic [3:0]        flashDin
);
  seqStrobes_t      strb;
  logic             switchOn;
  logic [CNT_W-1:0] cmdBits;
  logic [1:0]       curMode;
  logic             txBit;
  logic             sclk;
  logic             csActive;
  logic             cmdPhase;
  logic [CS_W-1:0]  csIdx;

  flash_rd_datapath #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CS_W(CS_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rdCs(rdCs), .rdAddr(rdAddr), .strb(strb), .flashDin(flashDin),
    .switchOn(switchOn), .cmdBits(cmdBits), .curMode(curMode),
    .txBit(txBit), .rdWord(rdData)
  );

  flash_rd_ctrl #(.CS_W(CS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdCs(rdCs), .switchOn(switchOn),
    .cmdBits(cmdBits), .curMode(curMode), .strb(strb), .sclk(sclk),
    .csActive(csActive), .cmdPhase(cmdPhase), .csIdx(csIdx),
    .respValid(rdReady), .respErr(rdErr)
  );

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    assign flashCsN[gi] = !(csActive && csIdx == CS_W'(gi));
  end

  assign pinOwn    = switchOn;
  assign flashSclk = sclk;
  assign flashOe   = cmdPhase;
  assign flashMosi = txBit & cmdPhase;
endmodule

// File: rtl/flash_rd_seq_chk.sv
module flash_rd_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReady,
  input logic              pinOwn,
  input logic [NUM_CS-1:0] flashCsN,
  input logic              flashSclk,
  input logic              flashMosi,
  input logic              flashOe
);
  p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~flashCsN));

  p_resp_cs_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> (&flashCsN));

  p_idle_pins_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!pinOwn && &flashCsN) |-> (!flashSclk && !flashOe));

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> !rdReady);

  p_mosi_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    flashSclk |-> $stable(flashMosi));

  p_sclk_needs_cs_r11: assert property (@(posedge clk) disable iff (!rstN)
    flashSclk |-> !(&flashCsN));
endmodule

bind flash_rd_seq flash_rd_seq_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rstN(rstN), .rdReady(rdReady), .pinOwn(pinOwn),
  .flashCsN(flashCsN), .flashSclk(flashSclk), .flashMosi(flashMosi),
  .flashOe(flashOe)
);

// File: tb/flash_rd_seq_tb_top.sv
module flash_rd_seq_tb_top;
  localparam int NUM_CS = 4;
  localparam int ADDR_W = 24;
  localparam int CS_W   = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [7:0]        cfgAddr = '0;
  logic [31:0]       cfgWdata = '0;
  logic              rdReq = 1'b0;
  logic [CS_W-1:0]   rdCs = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic              rdReady, rdErr, pinOwn, flashSclk, flashMosi, flashOe;
  logic [31:0]       rdData;
  logic [NUM_CS-1:0] flashCsN;
  logic [3:0]        flashDin = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  flash_rd_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rdReq(rdReq), .rdCs(rdCs), .rdAddr(rdAddr), .rdReady(rdReady), .rdData(rdData),
    .rdErr(rdErr), .pinOwn(pinOwn), .flashCsN(flashCsN), .flashSclk(flashSclk),
    .flashMosi(flashMosi), .flashOe(flashOe), .flashDin(flashDin)
  );

  // Flash model: decodes the command from the serial line and answers arithmetically
  int          cmdBitsM = 8;
  int          aM = 1, dM = 0, laneM = 1;
  int          cntM = 0, dataClk = 0, pos = 0, csFalls = 0, sclkRises = 0;
  logic [63:0] shM = '0;
  logic [63:0] dumM = '0, addrM = '0, opM = '0;
  logic [31:0] wordM = '0, outW;
  logic [NUM_CS-1:0] csSeen = '0;
  wire         allHigh = &flashCsN;

  always @(negedge allHigh) begin
    cntM = 0; shM = '0; dataClk = 0; pos = 0;
    csFalls++;
    csSeen = ~flashCsN;
  end

  always @(posedge flashSclk) begin
    sclkRises++;
    if (cntM < cmdBitsM) begin
      shM = {shM[62:0], flashMosi};
      cntM++;
      if (cntM == cmdBitsM) begin
        dumM  = shM & ((64'd1 << (8 * dM)) - 64'd1);
        addrM = (shM >> (8 * dM)) & ((64'd1 << (8 * aM)) - 64'd1);
        opM   = (shM >> (8 * dM + 8 * aM)) & 64'hFF;
        wordM = {opM[7:0], addrM[23:0]} ^ 32'h5A3C96E1;
      end
    end else dataClk++;
  end

  always @(negedge flashSclk) begin
    if (cntM == cmdBitsM) begin
      outW = wordM << pos;
      case (laneM)
        4:       flashDin = outW[31:28];
        2:       flashDin = {2'b00, outW[31:30]};
        default: flashDin = {2'b00, outW[31], 1'b0};
      endcase
      pos += laneM;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doRead(input logic [CS_W-1:0] cs, input logic [ADDR_W-1:0] a,
                        output logic [31:0] data, output logic err);
    int waitCnt = 0;
    @(negedge clk);
    rdReq = 1'b1; rdCs = cs; rdAddr = a;
    do begin
      @(negedge clk);
      waitCnt++;
    end while (!rdReady && waitCnt < 2000);
    check(rdReady, "R10", "ready arrives", 64'(rdReady), 64'd1);
    data = rdData; err = rdErr;
    rdReq = 1'b0;
    @(negedge clk);
    check(!rdReady, "R10", "ready single pulse", 64'(rdReady), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] data;
    logic        err;
    int          fallsBefore, risesBefore, idx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(&flashCsN, "R1", "cs high", 64'(flashCsN), 64'hF);
    check(!flashSclk && !flashOe, "R1", "sclk/oe low", 64'({flashSclk, flashOe}), 64'd0);
    check(!rdReady, "R1", "ready low", 64'(rdReady), 64'd0);
    check(!pinOwn, "R1", "routing bit clear", 64'(pinOwn), 64'd0);

    // R2: refused read while pins belong to the command engine
    fallsBefore = csFalls; risesBefore = sclkRises;
    doRead(2'd1, 24'h123456, data, err);
    check(err, "R2", "error response", 64'(err), 64'd1);
    check(csFalls == fallsBefore, "R2", "no cs fall", 64'(csFalls), 64'(fallsBefore));
    check(sclkRises == risesBefore, "R2", "no sclk", 64'(sclkRises), 64'(risesBefore));

    cfgWrite(8'h40, 32'h1);
    check(pinOwn, "R3", "routing bit set", 64'(pinOwn), 64'd1);

    idx = 0;
    for (int mi = 0; mi < 3; mi++) begin
      for (int a = 1; a <= 4; a++) begin
        for (int d = 0; d <= 3; d++) begin
          for (int c = 0; c < NUM_CS; c++) begin
            logic [1:0]        modeCode;
            logic [7:0]        op;
            logic [ADDR_W-1:0] addr;
            logic [63:0]       expAddr;
            logic [31:0]       expData;
            modeCode = (mi == 0) ? 2'd0 : (mi == 1) ? 2'd1 : 2'd3;
            laneM    = (mi == 0) ? 1 : (mi == 1) ? 2 : 4;
            op       = 8'(8'h03 + 8'd37 * 8'(idx));
            addr     = ADDR_W'(32'h13579B + 32'h010305 * 32'(idx));
            aM = a; dM = d; cmdBitsM = 8 + 8 * a + 8 * d;
            expAddr  = 64'(addr) & ((64'd1 << (8 * a)) - 64'd1);
            expData  = {op, expAddr[23:0]} ^ 32'h5A3C96E1;
            cfgWrite(8'(8'h54 + 4 * c),
                     {18'd0, modeCode, 2'(d), 2'(a - 1), op});
            fallsBefore = csFalls;
            doRead(CS_W'(c), addr, data, err);
            check(opM[7:0] == op, "R4", "opcode", opM, 64'(op));
            check(addrM == expAddr, "R5", "address", addrM, expAddr);
            check(dumM == 64'd0, "R6", "dummy bits low", dumM, 64'd0);
            check(dataClk == 32 / laneM, "R7", "data clocks", 64'(dataClk), 64'(32 / laneM));
            check(data == expData, "R8", "read word", 64'(data), 64'(expData));
            check(csSeen == NUM_CS'(1 << c), "R9", "selected cs", 64'(csSeen), 64'(1 << c));
            check(csFalls == fallsBefore + 1, "R9", "one cs fall", 64'(csFalls), 64'(fallsBefore + 1));
            check(!err, "R10", "no error", 64'(err), 64'd0);
            idx++;
          end
        end
      end
    end

    cfgWrite(8'h40, 32'h0);
    check(!pinOwn, "R3", "routing bit cleared", 64'(pinOwn), 64'd0);
    fallsBefore = csFalls;
    doRead(2'd0, 24'h000010, data, err);
    check(err, "R2", "error after release", 64'(err), 64'd1);
    check(csFalls == fallsBefore, "R2", "no cs after release", 64'(csFalls), 64'(fallsBefore));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule